// File: doc/BRIEF.md
# Boot ROM Space Decoder

This block watches the top 16 MiB of a 32-bit processor address space, the window set aside for boot ROM and flash. It decides where each access in that window goes. An access either selects one of two 8 MiB banks on the local memory bus through an active-low chip select, or it is sent on to the PCI bus. For every access inside the window, the block also raises a flag that tells the memory controller to neither generate nor check parity or ECC.

The routing depends on two settings. A strap level, sampled at the clock edge that ends reset, sets the default home of the ROM window: the local bus or PCI. A split-mode configuration bit matters only when the strap selects PCI. In that case it returns the lower 8 MiB of the window to the local bus and leaves the upper half on PCI. In split mode, a status output tells the system that the local bank has to be wired with a full 64-bit data path.

Each decision is registered, so the outputs appear one clock after the valid address. Address bits below the bank-select bit are never examined, which lets a partly populated bank alias onto the devices it actually holds.

Top module: `boot_rom_decoder`

## Requirements
- R1: An address whose bits 31:24 are not all ones gives no chip select (both `cs0_n_o` and `cs1_n_o` high), and leaves `pci_fwd_o`, `local_o` and `par_sup_o` low.
- R2: With the strap captured as 1 (local ROM), a valid window hit with address bit 23 = 1 drives `cs0_n_o` low, and a hit with bit 23 = 0 drives `cs1_n_o` low. Either select shows in the cycle after the address is sampled.
- R3: Address bits 22:0 have no effect on any decode output. Only bits 31:24 and bit 23 matter.
- R4: With the strap captured as 0 (PCI) and `split_en_i` = 0, every valid window hit raises `pci_fwd_o` and leaves both chip selects high.
- R5: With the strap captured as 0 and `split_en_i` = 1, a hit with bit 23 = 0 drives `cs1_n_o` low and raises `local_o`. A hit with bit 23 = 1 raises `pci_fwd_o`. `cs0_n_o` stays high.
- R6: `par_sup_o` is 1 for every valid window hit, whichever target is chosen, and 0 otherwise.
- R7: At most one of {`cs0_n_o` low, `cs1_n_o` low, `pci_fwd_o`} holds in any cycle. `local_o` is 1 exactly when a chip select is low. When `valid_i` was low, all decode outputs are idle.
- R8: `strap_i` is captured at the first rising clock edge after `rst_n` goes high. Later changes of `strap_i` do not change the routing.
- R9: `cs0_oe_o` is 0 while reset is asserted and until the capture edge, so the chip-select pin serves as a strap input during that time. It is 1 from then on.
- R10: `wide64_o` is 1 one cycle after a cycle in which the captured strap is 0 and `split_en_i` is 1. Otherwise it is 0.
- R11: While `rst_n` is low, both chip selects are high and `pci_fwd_o`, `local_o`, `par_sup_o` and `wide64_o` are 0.
- R12: With the strap captured as 1, `split_en_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | 32 | Access address |
| valid_i | input | 1 | Access valid strobe |
| split_en_i | input | 1 | Split mode: lower half of the window to the local bus when the ROM sits on PCI |
| strap_i | input | 1 | Level seen on the bank 0 select pin during reset (1 = local ROM, 0 = PCI) |
| cs0_n_o | output | 1 | Bank 0 (upper 8 MiB) chip select, active low |
| cs0_oe_o | output | 1 | Output enable for the bank 0 select pin |
| cs1_n_o | output | 1 | Bank 1 (lower 8 MiB) chip select, active low |
| pci_fwd_o | output | 1 | Access forwarded to PCI |
| local_o | output | 1 | Access served on the local memory bus |
| par_sup_o | output | 1 | Parity/ECC suppress for this access |
| wide64_o | output | 1 | Local bank must use the 64-bit data path (split mode) |

## Verification
The assertions check the following on every cycle:
- the chip selects and the PCI flag are mutually exclusive;
- `local_o` agrees with the selects;
- nothing decodes after an idle strobe or an out-of-window address;
- suppression accompanies every routed access;
- bank 0 is never selected while the ROM sits on PCI;
- the captured strap never moves after the capture edge;
- the pin enable stays low through reset.

Only the bench scenarios can show the following:
- that the bank and target chosen for each address match the intended map under each strap and split combination;
- that low address bits alias;
- that a strap change after reset is ignored;
- that `wide64_o` follows its inputs with one cycle of delay.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

  // Registered decode result driven to the pins
  typedef struct packed {
    logic cs0_n;
    logic cs1_n;
    logic pci_fwd;
    logic local_hit;
    logic par_sup;
  } rom_dec_t;

  localparam rom_dec_t ROM_DEC_IDLE = '{cs0_n: 1'b1, cs1_n: 1'b1,
                                        pci_fwd: 1'b0, local_hit: 1'b0,
                                        par_sup: 1'b0};

endpackage

// File: rtl/brd_strap_latch.sv
module brd_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic live_o,
  output logic strap_local_o
);

  logic live_q, live_d;
  logic strap_q, strap_d;

  // Capture only on the edge that ends reset, then hold
  always_comb begin
    live_d  = 1'b1;
    strap_d = live_q ? strap_q : strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      strap_q <= 1'b0;
    end else begin
      live_q  <= live_d;
      strap_q <= strap_d;
    end
  end

  assign live_o        = live_q;
  assign strap_local_o = strap_q;

  // R8: strap value is frozen once the block has left reset
  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> $stable(strap_q));

endmodule

// File: rtl/brd_region_decode.sv
module brd_region_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ROM_LOG2 = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_region_o,
  output logic              upper_half_o
);

  localparam int unsigned TAG_W = ADDR_W - ROM_LOG2;
  localparam int unsigned SEL_B = ROM_LOG2 - 1;

  logic [TAG_W-1:0] tag;
  logic             unused_alias_bits;

  assign tag          = addr_i[ADDR_W-1:ROM_LOG2];
  assign in_region_o  = &tag;
  assign upper_half_o = addr_i[SEL_B];
  // Bits below the bank select alias onto populated devices
  assign unused_alias_bits = ^addr_i[SEL_B-1:0];

endmodule

// File: rtl/brd_route.sv
module brd_route
  import boot_rom_pkg::*;
(
  input  logic     live_i,
  input  logic     valid_i,
  input  logic     in_region_i,
  input  logic     upper_half_i,
  input  logic     strap_local_i,
  input  logic     split_en_i,
  output rom_dec_t dec_o
);

  logic hit;
  logic to_local;

  always_comb begin
    hit      = live_i & valid_i & in_region_i;
    // Local when strapped local, or lower half returned in split mode
    to_local = strap_local_i | (split_en_i & ~upper_half_i);

    dec_o           = ROM_DEC_IDLE;
    dec_o.cs0_n     = ~(hit & to_local & upper_half_i);
    dec_o.cs1_n     = ~(hit & to_local & ~upper_half_i);
    dec_o.pci_fwd   = hit & ~to_local;
    dec_o.local_hit = hit & to_local;
    dec_o.par_sup   = hit;
  end

endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder
  import boot_rom_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ROM_LOG2 = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              split_en_i,
  input  logic              strap_i,
  output logic              cs0_n_o,
  output logic              cs0_oe_o,
  output logic              cs1_n_o,
  output logic              pci_fwd_o,
  output logic              local_o,
  output logic              par_sup_o,
  output logic              wide64_o
);

  localparam int unsigned TAG_W = ADDR_W - ROM_LOG2;

  logic     live;
  logic     strap_local;
  logic     in_region;
  logic     upper_half;
  rom_dec_t dec_d, dec_q;
  logic     wide_d, wide_q;

  brd_strap_latch u_strap (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_i       (strap_i),
    .live_o        (live),
    .strap_local_o (strap_local)
  );

  brd_region_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_LOG2 (ROM_LOG2)
  ) u_region (
    .addr_i       (addr_i),
    .in_region_o  (in_region),
    .upper_half_o (upper_half)
  );

  brd_route u_route (
    .live_i        (live),
    .valid_i       (valid_i),
    .in_region_i   (in_region),
    .upper_half_i  (upper_half),
    .strap_local_i (strap_local),
    .split_en_i    (split_en_i),
    .dec_o         (dec_d)
  );

  assign wide_d = live & ~strap_local & split_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= ROM_DEC_IDLE;
      wide_q <= 1'b0;
    end else begin
      dec_q  <= dec_d;
      wide_q <= wide_d;
    end
  end

  assign cs0_n_o   = dec_q.cs0_n;
  assign cs1_n_o   = dec_q.cs1_n;
  assign pci_fwd_o = dec_q.pci_fwd;
  assign local_o   = dec_q.local_hit;
  assign par_sup_o = dec_q.par_sup;
  assign wide64_o  = wide_q;
  assign cs0_oe_o  = live;

  // R7: one target at most per cycle
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~cs0_n_o, ~cs1_n_o, pci_fwd_o}) <= 1);

  // R7: local flag agrees with the chip selects
  p_local_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    local_o == (~cs0_n_o | ~cs1_n_o));

  // R7: idle strobe leaves everything deasserted
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (cs0_n_o && cs1_n_o && !pci_fwd_o && !par_sup_o));

  // R1: out-of-window address decodes to nothing
  p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(&addr_i[ADDR_W-1:ADDR_W-TAG_W]) |=>
      (cs0_n_o && cs1_n_o && !pci_fwd_o && !local_o && !par_sup_o));

  // R6: every routed access carries the suppress flag
  p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par_sup_o == (local_o | pci_fwd_o));

  // R5: bank 0 is never selected while the ROM sits on PCI
  p_no_cs0_on_pci_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_local |-> cs0_n_o);

  // R4: PCI forwarding only when strapped to PCI
  p_pci_strap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pci_fwd_o |-> !strap_local);

  // R9: pin not driven before the capture edge
  p_oe_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (!cs0_oe_o && cs0_n_o));

endmodule

// File: tb/sim_boot_rom_decoder.sv
module sim_boot_rom_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr;
  logic        valid;
  logic        split;
  logic        strap;
  logic        cs0_n, cs0_oe, cs1_n, pci_fwd, loc, par_sup, wide64;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  boot_rom_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr),
    .valid_i    (valid),
    .split_en_i (split),
    .strap_i    (strap),
    .cs0_n_o    (cs0_n),
    .cs0_oe_o   (cs0_oe),
    .cs1_n_o    (cs1_n),
    .pci_fwd_o  (pci_fwd),
    .local_o    (loc),
    .par_sup_o  (par_sup),
    .wide64_o   (wide64)
  );

  // {cs0_n, cs1_n, pci_fwd, local, par_sup, wide64}
  function automatic logic [5:0] model(input logic st, input logic sp,
                                       input logic v, input logic [31:0] a);
    logic hit, up, to_loc;
    hit    = v && (a[31:24] == 8'hFF);
    up     = a[23];
    to_loc = st || (sp && !up);
    return {!(hit && to_loc && up), !(hit && to_loc && !up),
            hit && !to_loc, hit && to_loc, hit, !st && sp};
  endfunction

  function automatic string req_of(input logic st, input logic sp,
                                   input logic v, input logic [31:0] a);
    if (!v) return "R7";
    if (a[31:24] != 8'hFF) return "R1";
    if (st) return "R2";
    if (sp) return "R5";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [5:0] act,
                       input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cs0_n cs1_n pci loc sup wide)",
               req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {cs0_n, cs1_n, pci_fwd, loc, par_sup, wide64};
  endfunction

  // Drive at a negedge, check one negedge later (one register stage)
  task automatic access(input logic st, input logic [31:0] a, input logic v,
                        input logic sp, input string req);
    addr = a; valid = v; split = sp;
    @(negedge clk);
    check(req, outs(), model(st, sp, v, a));
  endtask

  task automatic do_reset(input logic st);
    @(negedge clk);
    rst_n = 1'b0; strap = st; valid = 1'b0; split = 1'b0; addr = '0;
    @(negedge clk);
    // R11 reset state, R9 pin not driven
    check("R11", outs(), 6'b110000);
    n_chk++;
    if (cs0_oe !== 1'b0) begin
      n_fail++; $display("FAIL R9: cs0_oe actual %b expected 0", cs0_oe);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (cs0_oe !== 1'b1) begin
      n_fail++; $display("FAIL R9: cs0_oe actual %b expected 1", cs0_oe);
    end
    strap = ~st;  // R8: later strap changes must be ignored
  endtask

  task automatic random_run(input logic st, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      logic        v, sp;
      a = $urandom;
      case ($urandom % 4)
        0: ;
        1, 2: a[31:24] = 8'hFF;
        default: a[31:24] = 8'hFE | 8'($urandom % 2);
      endcase
      v  = ($urandom % 8) != 0;
      sp = 1'($urandom);
      access(st, a, v, sp, req_of(st, sp, v, a));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; addr = '0; valid = 1'b0; split = 1'b0; strap = 1'b1;

    // ---- strapped local ----
    do_reset(1'b1);
    access(1'b1, 32'hFF80_0000, 1'b1, 1'b0, "R2");
    access(1'b1, 32'hFF7F_FFFF, 1'b1, 1'b0, "R2");
    access(1'b1, 32'hFEFF_FFFF, 1'b1, 1'b0, "R1");
    access(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7");
    access(1'b1, 32'hFFC0_1234, 1'b1, 1'b0, "R3");
    access(1'b1, 32'hFF80_0001, 1'b1, 1'b0, "R3");
    access(1'b1, 32'hFF00_0000, 1'b1, 1'b1, "R12");
    access(1'b1, 32'hFFA0_0000, 1'b1, 1'b1, "R12");
    access(1'b1, 32'hFF00_0040, 1'b1, 1'b0, "R6");
    access(1'b1, 32'hFF00_0000, 1'b1, 1'b0, "R8");
    random_run(1'b1, 400);

    // ---- strapped PCI ----
    do_reset(1'b0);
    access(1'b0, 32'hFF80_0000, 1'b1, 1'b0, "R4");
    access(1'b0, 32'hFF00_0000, 1'b1, 1'b0, "R4");
    access(1'b0, 32'hFF7F_FFFF, 1'b1, 1'b1, "R5");
    access(1'b0, 32'hFF80_0000, 1'b1, 1'b1, "R5");
    access(1'b0, 32'h0000_0000, 1'b0, 1'b1, "R10");
    access(1'b0, 32'h0000_0000, 1'b0, 1'b0, "R10");
    access(1'b0, 32'hFFFF_0000, 1'b1, 1'b0, "R6");
    access(1'b0, 32'h7FFF_FFFF, 1'b1, 1'b1, "R1");
    access(1'b0, 32'hFF12_3456, 1'b1, 1'b1, "R8");
    random_run(1'b0, 400);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule